// File: doc/BRIEF.md
# DDR2 Command Protocol Checker

This block sits beside a DDR2 command bus and watches it without driving anything back. On every rising clock edge it decodes the chip selects together with the row strobe, column strobe and write enable lines into one command, for one chosen module out of four. It keeps an open or idle flag for each of the eight banks, a countdown that enforces the write-to-read turnaround, and the ages of the four most recent row activations.

Each protocol rule has its own error bit. A one-cycle pulse reports a violation one clock after the offending command is sampled. A sticky copy of the same bit stays set until reset. The timing values are static configuration pins. Commands addressed to the other three modules appear on the same bus but do not affect the checked module's state.

The block has no data stream, so every pin is a plain level signal with no handshake. There is nothing to back-pressure. The checker can never stall the bus it observes.

Top module: `ddr2_cmd_checker`

## Requirements
- R1: An ACTIVATE to a bank whose flag is open raises `err_pulse[0]` in the cycle after it is sampled.
- R2: A READ or a WRITE to a bank whose flag is idle raises `err_pulse[1]`.
- R3: A READ raises `err_pulse[2]` when fewer than (cfg_cl-1)+(cfg_bl/2)+cfg_twtr cycles separate it from the most recent WRITE. At exactly that distance, no error is raised.
- R4: An ACTIVATE raises `err_pulse[3]` when four earlier ACTIVATEs exist and the oldest of those four lies fewer than `cfg_tfaw` cycles back. At exactly `cfg_tfaw` cycles, no error is raised.
- R5: A REFRESH raises `err_pulse[4]` while any bank flag is open.
- R6: ACTIVATE sets the addressed bank's flag to open. PRECHARGE with `addr10`=0 clears only the addressed bank. PRECHARGE with `addr10`=1 clears all eight banks.
- R7: A command counts only when `cs_n[chk_rank]` is 0. The levels (ras_n,cas_n,we_n) decode as follows: 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 mode set, 111 no operation. Commands to other ranks, mode set and no operation change no state and raise no error.
- R8: `err_sticky[i]` becomes 1 at the same edge as `err_pulse[i]` and stays 1 until reset. Bit order is 0 activate-open, 1 access-idle, 2 turnaround, 3 four-activate window, 4 refresh-open.
- R9: During and right after reset, both error vectors are zero, all banks are idle, and no turnaround or window constraint is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 4 | Active-low chip selects, one per module |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| ba | input | 3 | Bank address |
| addr10 | input | 1 | Address bit 10; selects all banks on PRECHARGE |
| chk_rank | input | 2 | Index of the module whose commands are checked |
| cfg_cl | input | 4 | CAS latency in cycles (at least 1) |
| cfg_bl | input | 4 | Burst length, 4 or 8 |
| cfg_twtr | input | 4 | Internal write-to-read delay in cycles |
| cfg_tfaw | input | 6 | Four-activate window length in cycles |
| err_pulse | output | 5 | One-cycle per-rule violation flags |
| err_sticky | output | 5 | Per-rule flags held until reset |

## Verification
The assertions assume the following about the inputs:
- `chk_rank` and all `cfg_*` pins are constant outside reset.
- `cfg_cl` is at least 1.
- Each module receives at most one command per edge.

The stimulus meets these assumptions in three ways:
- It changes configuration and the checked rank only while reset is held.
- It drives every bus pin at the falling edge.
- It builds each cycle's pins from a single command code, so select and strobe levels always form a legal encoding.

// File: rtl/ddr2_chk_pkg.sv
package ddr2_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } bus_cmd_e;

  localparam int NUM_RULES    = 5;
  localparam int RULE_ACT_OPEN = 0;
  localparam int RULE_ACC_IDLE = 1;
  localparam int RULE_WR2RD    = 2;
  localparam int RULE_FOUR_ACT = 3;
  localparam int RULE_REF_OPEN = 4;

endpackage

// File: rtl/ddr2_cmd_decode.sv
module ddr2_cmd_decode
  import ddr2_chk_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  localparam int RANK_W = $clog2(NUM_RANKS)
) (
  input  logic [NUM_RANKS-1:0] cs_n,
  input  logic [RANK_W-1:0]    chk_rank,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  output bus_cmd_e             cmd
);

  logic picked;

  assign picked = ~cs_n[chk_rank];

  always_comb begin
    cmd = CMD_NOP;
    if (picked) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr2_bank_tracker.sv
module ddr2_bank_tracker
  import ddr2_chk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_cmd_e             cmd,
  input  logic [BA_W-1:0]      ba,
  input  logic                 addr10,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 err_act_open,
  output logic                 err_acc_idle,
  output logic                 err_ref_open
);

  logic hit_open;

  assign hit_open     = bank_open[ba];
  assign err_act_open = (cmd == CMD_ACT) && hit_open;
  assign err_acc_idle = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !hit_open;
  assign err_ref_open = (cmd == CMD_REF) && (|bank_open);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
      end else if ((cmd == CMD_ACT) && (ba == BA_W'(b))) begin
        bank_open[b] <= 1'b1;
      end else if ((cmd == CMD_PRE) && (addr10 || (ba == BA_W'(b)))) begin
        bank_open[b] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr2_wr2rd_timer.sv
module ddr2_wr2rd_timer
  import ddr2_chk_pkg::*;
#(
  parameter int CFG_W = 4,
  localparam int CNT_W = CFG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_cmd_e         cmd,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic [CFG_W-1:0] cfg_bl,
  input  logic [CFG_W-1:0] cfg_twtr,
  output logic             err_wr2rd
);

  logic [CNT_W-1:0] span_sum;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] remain;

  // cl + bl/2 + twtr; the required gap is this sum minus one and the
  // counter is loaded with the gap minus one.
  assign span_sum = CNT_W'(cfg_cl) + CNT_W'(cfg_bl >> 1) + CNT_W'(cfg_twtr);
  assign load_val = (span_sum >= CNT_W'(2)) ? (span_sum - CNT_W'(2)) : '0;

  assign err_wr2rd = (cmd == CMD_RD) && (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (cmd == CMD_WR) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddr2_act_window.sv
module ddr2_act_window
  import ddr2_chk_pkg::*;
#(
  parameter int WIN_W   = 6,
  parameter int HIST_N  = 4,
  localparam int AGE_W  = WIN_W + 1,
  localparam int PTR_W  = $clog2(HIST_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_cmd_e         cmd,
  input  logic [WIN_W-1:0] cfg_tfaw,
  output logic             err_four_act
);

  logic             is_act;
  logic [AGE_W-1:0] age [HIST_N];
  logic [PTR_W-1:0] oldest;

  assign is_act = (cmd == CMD_ACT);

  // A saturated age stands for "long ago" and never trips the window.
  assign err_four_act = is_act && (age[oldest] < AGE_W'(cfg_tfaw));

  for (genvar s = 0; s < HIST_N; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age[s] <= '1;
      end else if (is_act && (oldest == PTR_W'(s))) begin
        age[s] <= AGE_W'(1);
      end else if (age[s] != '1) begin
        age[s] <= age[s] + AGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oldest <= '0;
    end else if (is_act) begin
      oldest <= oldest + PTR_W'(1);
    end
  end

endmodule

// File: rtl/ddr2_cmd_checker.sv
module ddr2_cmd_checker
  import ddr2_chk_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int NUM_BANKS = 8,
  parameter int CFG_W     = 4,
  parameter int WIN_W     = 6,
  parameter int HIST_N    = 4,
  localparam int RANK_W   = $clog2(NUM_RANKS),
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 addr10,
  input  logic [RANK_W-1:0]    chk_rank,
  input  logic [CFG_W-1:0]     cfg_cl,
  input  logic [CFG_W-1:0]     cfg_bl,
  input  logic [CFG_W-1:0]     cfg_twtr,
  input  logic [WIN_W-1:0]     cfg_tfaw,
  output logic [NUM_RULES-1:0] err_pulse,
  output logic [NUM_RULES-1:0] err_sticky
);

  bus_cmd_e             cmd;
  logic [NUM_BANKS-1:0] bank_open;
  logic                 e_act_open;
  logic                 e_acc_idle;
  logic                 e_ref_open;
  logic                 e_wr2rd;
  logic                 e_four_act;
  logic [NUM_RULES-1:0] err_now;

  ddr2_cmd_decode #(.NUM_RANKS(NUM_RANKS)) u_decode (
    .cs_n     (cs_n),
    .chk_rank (chk_rank),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd)
  );

  ddr2_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .ba           (ba),
    .addr10       (addr10),
    .bank_open    (bank_open),
    .err_act_open (e_act_open),
    .err_acc_idle (e_acc_idle),
    .err_ref_open (e_ref_open)
  );

  ddr2_wr2rd_timer #(.CFG_W(CFG_W)) u_wr2rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .cfg_cl    (cfg_cl),
    .cfg_bl    (cfg_bl),
    .cfg_twtr  (cfg_twtr),
    .err_wr2rd (e_wr2rd)
  );

  ddr2_act_window #(.WIN_W(WIN_W), .HIST_N(HIST_N)) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .cfg_tfaw     (cfg_tfaw),
    .err_four_act (e_four_act)
  );

  always_comb begin
    err_now                = '0;
    err_now[RULE_ACT_OPEN] = e_act_open;
    err_now[RULE_ACC_IDLE] = e_acc_idle;
    err_now[RULE_WR2RD]    = e_wr2rd;
    err_now[RULE_FOUR_ACT] = e_four_act;
    err_now[RULE_REF_OPEN] = e_ref_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= '0;
      err_sticky <= '0;
    end else begin
      err_pulse  <= err_now;
      err_sticky <= err_sticky | err_now;
    end
  end

endmodule

// File: rtl/ddr2_cmd_checker_sva.sv
module ddr2_cmd_checker_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic [2:0] ba,
  input logic       addr10,
  input logic [1:0] chk_rank,
  input logic [7:0] bank_open,
  input logic [4:0] err_pulse,
  input logic [4:0] err_sticky
);

  logic on_rank;
  logic s_act;
  logic s_rw;
  logic s_ref;
  logic s_pall;
  logic s_real;

  assign on_rank = !cs_n[chk_rank];
  assign s_act   = on_rank && ({ras_n, cas_n, we_n} == 3'b011);
  assign s_rw    = on_rank && ({ras_n, cas_n} == 2'b10);
  assign s_ref   = on_rank && ({ras_n, cas_n, we_n} == 3'b001);
  assign s_pall  = on_rank && ({ras_n, cas_n, we_n} == 3'b010) && addr10;
  assign s_real  = on_rank && (s_act || s_rw || s_ref ||
                               ({ras_n, cas_n, we_n} == 3'b010));

  // R1
  a_r1_act_open_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (s_act && bank_open[ba]) |=> err_pulse[0]);

  // R2
  a_r2_access_idle_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rw && !bank_open[ba]) |=> err_pulse[1]);

  // R5
  a_r5_refresh_open_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ref && (|bank_open)) |=> err_pulse[4]);

  // R6: precharge-all leaves nothing open for the next refresh
  a_r6_pall_then_refresh_ok: assert property (@(posedge clk) disable iff (!rst_n)
    s_pall ##1 s_ref |=> !err_pulse[4]);

  // R7: nothing that is not a checked command produces a pulse
  a_r7_silent_when_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !s_real |=> (err_pulse == 5'b0));

  // R8
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

endmodule

bind ddr2_cmd_checker ddr2_cmd_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr10     (addr10),
  .chk_rank   (chk_rank),
  .bank_open  (bank_open),
  .err_pulse  (err_pulse),
  .err_sticky (err_sticky)
);

// File: tb/ddr2_cmd_checker_tb.sv
module ddr2_cmd_checker_tb;

  localparam int C_NOP = 0;
  localparam int C_ACT = 1;
  localparam int C_RD  = 2;
  localparam int C_WR  = 3;
  localparam int C_PRE = 4;
  localparam int C_REF = 5;
  localparam int C_MRS = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cs_n = 4'hF;
  logic       ras_n = 1'b1;
  logic       cas_n = 1'b1;
  logic       we_n = 1'b1;
  logic [2:0] ba = '0;
  logic       addr10 = 1'b0;
  logic [1:0] chk_rank = 2'd1;
  logic [3:0] cfg_cl = 4'd5;
  logic [3:0] cfg_bl = 4'd8;
  logic [3:0] cfg_twtr = 4'd3;
  logic [5:0] cfg_tfaw = 6'd20;
  logic [4:0] err_pulse;
  logic [4:0] err_sticky;

  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;
  logic [4:0] expq[$];
  logic [4:0] acc;
  logic [4:0] mon_exp;
  bit         open_m[8];
  int         cyc;
  int         wr_t;
  bit         wr_v;
  int         acts[$];

  always #2 clk = ~clk;

  ddr2_cmd_checker u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr10     (addr10),
    .chk_rank   (chk_rank),
    .cfg_cl     (cfg_cl),
    .cfg_bl     (cfg_bl),
    .cfg_twtr   (cfg_twtr),
    .cfg_tfaw   (cfg_tfaw),
    .err_pulse  (err_pulse),
    .err_sticky (err_sticky)
  );

  function automatic string rule_tag(int b);
    case (b)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_vec(string tag, logic [4:0] got, logic [4:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s got=%b expected=%b", tag, got, want);
    end
  endtask

  // Scoreboard monitor: compares each pulse vector one edge after its command.
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      mon_exp = expq.pop_front();
      checks++;
      if (err_pulse !== mon_exp) begin
        fails++;
        for (int b = 0; b < 5; b++) begin
          if (err_pulse[b] !== mon_exp[b]) begin
            $display("FAIL %s pulse cycle got=%b expected=%b",
                     rule_tag(b), err_pulse, mon_exp);
            break;
          end
        end
      end
    end
  end

  // Driver with reference model: one call per clock cycle.
  task automatic issue(int rank, int c, int b, bit a10);
    logic [4:0] e;
    int need;
    e = '0;
    @(negedge clk);
    cs_n = 4'hF;
    {ras_n, cas_n, we_n} = 3'b111;
    if (c != C_NOP) cs_n[rank] = 1'b0;
    case (c)
      C_ACT: {ras_n, cas_n, we_n} = 3'b011;
      C_RD:  {ras_n, cas_n, we_n} = 3'b101;
      C_WR:  {ras_n, cas_n, we_n} = 3'b100;
      C_PRE: {ras_n, cas_n, we_n} = 3'b010;
      C_REF: {ras_n, cas_n, we_n} = 3'b001;
      C_MRS: {ras_n, cas_n, we_n} = 3'b000;
      default: ;
    endcase
    ba = 3'(b);
    addr10 = a10;
    if (c != C_NOP && rank == int'(chk_rank)) begin
      need = (int'(cfg_cl) - 1) + int'(cfg_bl) / 2 + int'(cfg_twtr);
      case (c)
        C_ACT: begin
          if (open_m[b]) e[0] = 1'b1;
          if (acts.size() >= 4 && (cyc - acts[acts.size()-4]) < int'(cfg_tfaw)) e[3] = 1'b1;
          open_m[b] = 1'b1;
          acts.push_back(cyc);
        end
        C_RD: begin
          if (!open_m[b]) e[1] = 1'b1;
          if (wr_v && (cyc - wr_t) < need) e[2] = 1'b1;
        end
        C_WR: begin
          if (!open_m[b]) e[1] = 1'b1;
          wr_v = 1'b1;
          wr_t = cyc;
        end
        C_PRE: begin
          if (a10) begin
            for (int k = 0; k < 8; k++) open_m[k] = 1'b0;
          end else begin
            open_m[b] = 1'b0;
          end
        end
        C_REF: begin
          for (int k = 0; k < 8; k++) if (open_m[k]) e[4] = 1'b1;
        end
        default: ;
      endcase
    end
    cyc++;
    acc |= e;
    expq.push_back(e);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(0, C_NOP, 0, 1'b0);
  endtask

  task automatic drain();
    @(negedge clk);
    cs_n = 4'hF;
    {ras_n, cas_n, we_n} = 3'b111;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 4'hF;
    {ras_n, cas_n, we_n} = 3'b111;
    expq.delete();
    acts.delete();
    for (int k = 0; k < 8; k++) open_m[k] = 1'b0;
    wr_v = 1'b0;
    wr_t = 0;
    cyc = 0;
    acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_vec("R9 pulse in reset", err_pulse, 5'b0);
    check_vec("R9 sticky in reset", err_sticky, 5'b0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_vec("R9 pulse after reset", err_pulse, 5'b0);
    check_vec("R9 sticky after reset", err_sticky, 5'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Phase 1: rank 1 checked, CL5 BL8 tWTR3 -> gap 11, window 20
    chk_rank = 2'd1;
    cfg_cl = 4'd5; cfg_bl = 4'd8; cfg_twtr = 4'd3; cfg_tfaw = 6'd20;
    do_reset();

    issue(1, C_RD, 0, 1'b0);        // R2: read to idle bank
    issue(1, C_ACT, 0, 1'b0);       // R6: opens bank 0
    issue(1, C_ACT, 0, 1'b0);       // R1: second activate to open bank
    issue(1, C_WR, 0, 1'b0);
    nops(9);
    issue(1, C_RD, 0, 1'b0);        // R3: gap 10 < 11
    issue(1, C_RD, 0, 1'b0);        // R3 boundary: gap 11 is legal
    issue(1, C_MRS, 0, 1'b0);       // R7: mode set has no effect
    issue(1, C_REF, 0, 1'b0);       // R5: refresh with bank 0 open
    issue(1, C_PRE, 0, 1'b1);       // R6: precharge all
    issue(1, C_REF, 0, 1'b0);       // R5: now legal
    issue(1, C_ACT, 1, 1'b0);
    issue(1, C_ACT, 2, 1'b0);
    issue(1, C_PRE, 1, 1'b0);       // R6: closes bank 1 only
    issue(1, C_RD, 1, 1'b0);        // R2/R6: bank 1 idle
    issue(1, C_RD, 2, 1'b0);        // R6: bank 2 still open
    issue(0, C_ACT, 2, 1'b0);       // R7: other rank ignored
    issue(0, C_REF, 0, 1'b0);       // R7
    issue(2, C_RD, 5, 1'b0);        // R7
    issue(3, C_ACT, 2, 1'b0);       // R7
    issue(1, C_PRE, 0, 1'b1);
    nops(25);
    // R4: four-activate window
    for (int b = 0; b < 5; b++) issue(1, C_ACT, b, 1'b0);  // fifth violates
    nops(16);
    issue(1, C_ACT, 5, 1'b0);       // R4 boundary: exactly 20 back
    issue(1, C_ACT, 6, 1'b0);
    issue(1, C_ACT, 7, 1'b0);
    issue(1, C_PRE, 0, 1'b1);
    issue(1, C_ACT, 0, 1'b0);
    issue(1, C_ACT, 1, 1'b0);       // R4: oldest only 5 back
    drain();
    check_vec("R8 sticky accumulates", err_sticky, acc);
    nops(3);
    drain();
    check_vec("R8 sticky holds over idle", err_sticky, acc);

    // Phase 2: rank 2 checked, BL4 -> gap 9
    chk_rank = 2'd2;
    cfg_bl = 4'd4;
    do_reset();
    issue(2, C_ACT, 3, 1'b0);
    issue(1, C_RD, 3, 1'b0);        // R7: rank 1 now unchecked
    issue(2, C_WR, 3, 1'b0);
    nops(7);
    issue(2, C_RD, 3, 1'b0);        // R3: gap 8 < 9
    issue(2, C_RD, 3, 1'b0);        // R3 boundary: gap 9
    issue(2, C_ACT, 3, 1'b0);       // R1
    issue(2, C_REF, 0, 1'b0);       // R5
    drain();
    check_vec("R8 sticky phase 2", err_sticky, acc);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule